// File: doc/BRIEF.md
# Cache Access Event Counter Bank

This block sits beside a cache controller and keeps a bank of saturating event counters that software reads through a small register port. The controller reports two kinds of activity. Each bus transaction is reported once with its start address, byte length and direction. Each cache-line access is reported as a lookup event carrying the direction, the hit or miss result, whether the line was dirty before the access, and whether the hit was caught by hazard protection.

From the transaction report the bank works out how many cache lines the transaction touches. It adds that number to the read-segment or write-segment count. A port that only issues single-line accesses can assert a flag that makes every transaction count as one segment. From the lookup events it counts read hits and write hits. It counts first write hits only when a write hit finds the line clean. Hazard-locked hits get separate read and write counts, and each locked hit is also counted as an ordinary hit.

The register port reads one counter per request, with one cycle of latency. A write to the control index zeroes every counter in a single cycle, and that clear takes priority over any event arriving in the same cycle. Counters stop at all ones instead of wrapping.

Top module: `cache_event_counters`

## Requirements
- R1: For a transaction with nonzero length, the read-segment counter (index 0, `txn_write`=0) or the write-segment counter (index 1, `txn_write`=1) increases by `((addr+len-1) >> 6) - (addr >> 6) + 1`. The line size is 64 bytes, and the end address is computed one bit wider than the address so it does not wrap.
- R2: When `txn_single` is 1, a transaction with nonzero length adds exactly one segment, whatever its address and length.
- R3: Every lookup with `evt_write`=1 and `evt_hit`=1 increases the write-hit counter (index 3) by one, whatever the dirty state or hazard flag.
- R4: The first-write-hit counter (index 4) increases by one on a write hit with `evt_dirty_before`=0, and stays unchanged on a write hit with `evt_dirty_before`=1.
- R5: A hit with `evt_hazard`=1 increases the locked-read-hit counter (index 5) or the locked-write-hit counter (index 6), chosen by direction, and also increases the ordinary hit counter of that direction.
- R6: Every lookup with `evt_write`=0 and `evt_hit`=1 increases the read-hit counter (index 2) by one.
- R7: A counter that would pass all ones holds at all ones, including when a multi-segment increment crosses the limit.
- R8: An `wr_en` with `wr_idx`=7 sets every counter to zero at that clock edge, even if a transaction or lookup arrives in the same cycle.
- R9: `rd_en` with `rd_idx` gives `rd_valid`=1 on the following cycle. `rd_data` then holds the counter value from before that edge's update. Index 7 reads as zero.
- R10: After synchronous reset, every counter reads zero and `rd_valid` is 0.
- R11: A lookup with `evt_hit`=0 changes no counter.
- R12: A transaction with `txn_len`=0 adds no segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | Transaction report strobe |
| txn_write | input | 1 | Transaction direction, 1 = write |
| txn_single | input | 1 | Port issues single-line accesses only |
| txn_addr | input | ADDR_W (32) | Transaction start byte address |
| txn_len | input | LEN_W (12) | Transaction length in bytes |
| evt_valid | input | 1 | Line lookup strobe |
| evt_write | input | 1 | Lookup direction, 1 = write |
| evt_hit | input | 1 | Lookup hit |
| evt_dirty_before | input | 1 | Line was dirty before this access |
| evt_hazard | input | 1 | Hit needed hazard resolution |
| rd_en | input | 1 | Register read request |
| rd_idx | input | 3 | Register index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | COUNT_W (32) | Read data |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index written; 7 clears all |

## Verification
The bench drives transactions that start and end at line boundaries, straddle them by one byte, reach the top of the address space, have zero length, or use the maximum length. A segment calculation that is off by one, or that wraps the end address, shows up in the segment totals. It mixes write hits on clean and dirty lines, with and without hazard, to catch a first-write count that ignores the dirty state, or a locked hit that is left out of the ordinary hit total. Narrow counters are pushed past their limit with single and multi-segment increments, so a wrapping adder reads back a small value. A clear is issued in the same cycle as live events, so an event-over-clear priority leaves nonzero counts.

// File: rtl/cec_pkg.sv
// Shared definitions for the cache event counter bank.
// Assumes the register index space is three bits wide.
package cec_pkg;

    // Register index map; the index is the software-visible address.
    typedef enum logic [2:0] {
        IDX_RD_SEG   = 3'd0,
        IDX_WR_SEG   = 3'd1,
        IDX_RD_HIT   = 3'd2,
        IDX_WR_HIT   = 3'd3,
        IDX_WR_FIRST = 3'd4,
        IDX_RD_LOCK  = 3'd5,
        IDX_WR_LOCK  = 3'd6,
        IDX_CTRL     = 3'd7
    } reg_idx_e;

    localparam int NUM_CNT = 7;
    localparam int IDX_W   = 3;

endpackage

// File: rtl/cec_seg_calc.sv
// Segment calculator: number of cache lines a transaction touches.
// Assumes LEN_W > LINE_SHIFT. The end address is computed one bit wider
// than the address so transactions near the top of memory do not wrap.
// A zero-length transaction spans no lines.
module cec_seg_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int LINE_BYTES = 64,
    parameter int SEG_W      = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              single,
    output logic [SEG_W-1:0]  seg_count
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int EXT_W      = ADDR_W + 1;

    logic [EXT_W-1:0] start_ext;
    logic [EXT_W-1:0] end_ext;
    logic [EXT_W-1:0] first_line;
    logic [EXT_W-1:0] last_line;
    logic [EXT_W-1:0] span;

    // Purpose: derive first and last line indices and their distance.
    always_comb begin
        start_ext  = {1'b0, addr};
        end_ext    = start_ext + EXT_W'(len) - EXT_W'(1);
        first_line = start_ext >> LINE_SHIFT;
        last_line  = end_ext >> LINE_SHIFT;
        span       = last_line - first_line + EXT_W'(1);
    end

    // Purpose: select zero, one or the computed span, clamping defensively.
    always_comb begin
        if (len == '0) begin
            seg_count = '0;
        end else if (single) begin
            seg_count = SEG_W'(1);
        end else if (|span[EXT_W-1:SEG_W]) begin
            seg_count = '1;
        end else begin
            seg_count = span[SEG_W-1:0];
        end
    end

endmodule

// File: rtl/cec_event_decode.sv
// Event decoder: turns one transaction report and one lookup event per
// cycle into an increment amount for every counter in the bank.
// Assumes at most one transaction and one lookup per cycle.
module cec_event_decode
    import cec_pkg::*;
#(
    parameter int INC_W = 7
) (
    input  logic                           txn_valid,
    input  logic                           txn_write,
    input  logic [INC_W-1:0]               seg_count,
    input  logic                           evt_valid,
    input  logic                           evt_write,
    input  logic                           evt_hit,
    input  logic                           evt_dirty_before,
    input  logic                           evt_hazard,
    output logic [NUM_CNT-1:0][INC_W-1:0]  inc
);
    logic rd_hit;
    logic wr_hit;

    // Purpose: qualify hits by direction.
    always_comb begin
        rd_hit = evt_valid && evt_hit && !evt_write;
        wr_hit = evt_valid && evt_hit && evt_write;
    end

    // Purpose: build the per-counter increment vector.
    always_comb begin
        inc = '0;
        if (txn_valid && !txn_write) inc[IDX_RD_SEG] = seg_count;
        if (txn_valid && txn_write)  inc[IDX_WR_SEG] = seg_count;
        if (rd_hit)                  inc[IDX_RD_HIT] = INC_W'(1);
        if (wr_hit)                  inc[IDX_WR_HIT] = INC_W'(1);
        if (wr_hit && !evt_dirty_before) inc[IDX_WR_FIRST] = INC_W'(1);
        if (rd_hit && evt_hazard)    inc[IDX_RD_LOCK] = INC_W'(1);
        if (wr_hit && evt_hazard)    inc[IDX_WR_LOCK] = INC_W'(1);
    end

endmodule

// File: rtl/cec_sat_counter.sv
// Saturating accumulator with synchronous clear.
// Adds an increment of INC_W bits each cycle and holds at all ones.
// Clear has priority over the increment.
module cec_sat_counter #(
    parameter int COUNT_W = 32,
    parameter int INC_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [INC_W-1:0]   inc,
    output logic [COUNT_W-1:0] count
);
    localparam int SUM_W = ((COUNT_W > INC_W) ? COUNT_W : INC_W) + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'({COUNT_W{1'b1}});

    logic [SUM_W-1:0]   sum;
    logic [COUNT_W-1:0] next;

    // Purpose: widened add and clamp at the counter's limit.
    always_comb begin
        sum  = SUM_W'(count) + SUM_W'(inc);
        next = (sum > LIMIT) ? {COUNT_W{1'b1}} : sum[COUNT_W-1:0];
    end

    // Purpose: register the count; reset and clear both zero it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= next;
        end
    end

endmodule

// File: rtl/cec_read_port.sv
// Registered read port: one request per cycle, data one cycle later.
// Indices beyond the counter bank read as zero.
module cec_read_port
    import cec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [IDX_W-1:0]                rd_idx,
    input  logic [NUM_CNT-1:0][COUNT_W-1:0] counts,
    output logic                            rd_valid,
    output logic [COUNT_W-1:0]              rd_data
);
    logic [COUNT_W-1:0] sel;

    // Purpose: pick the addressed counter, zero for unmapped indices.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_idx == IDX_W'(i)) sel = counts[i];
        end
    end

    // Purpose: register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? sel : rd_data;
        end
    end

endmodule

// File: rtl/cache_event_counters.sv
// Cache access event counter bank (top).
// Counts line segments per transaction, read/write hits, first write hits
// on clean lines and hazard-locked hits. Software reads counters through a
// one-cycle read port; a write to index 7 clears the whole bank.
// Assumes the controller issues at most one transaction report and one
// lookup event per cycle.
module cache_event_counters
    import cec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int LINE_BYTES = 64,
    parameter int COUNT_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_valid,
    input  logic               txn_write,
    input  logic               txn_single,
    input  logic [ADDR_W-1:0]  txn_addr,
    input  logic [LEN_W-1:0]   txn_len,
    input  logic               evt_valid,
    input  logic               evt_write,
    input  logic               evt_hit,
    input  logic               evt_dirty_before,
    input  logic               evt_hazard,
    input  logic               rd_en,
    input  logic [2:0]         rd_idx,
    output logic               rd_valid,
    output logic [COUNT_W-1:0] rd_data,
    input  logic               wr_en,
    input  logic [2:0]         wr_idx
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int SEG_W      = LEN_W - LINE_SHIFT + 1;

    logic [SEG_W-1:0]                 seg_count;
    logic [NUM_CNT-1:0][SEG_W-1:0]    inc;
    logic [NUM_CNT-1:0][COUNT_W-1:0]  cnt_q;
    logic                             clr_req;

    // Purpose: decode the clear command from the write port.
    always_comb begin
        clr_req = wr_en && (wr_idx == IDX_CTRL);
    end

    cec_seg_calc #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .LINE_BYTES(LINE_BYTES),
        .SEG_W     (SEG_W)
    ) u_seg (
        .addr     (txn_addr),
        .len      (txn_len),
        .single   (txn_single),
        .seg_count(seg_count)
    );

    cec_event_decode #(
        .INC_W(SEG_W)
    ) u_dec (
        .txn_valid       (txn_valid),
        .txn_write       (txn_write),
        .seg_count       (seg_count),
        .evt_valid       (evt_valid),
        .evt_write       (evt_write),
        .evt_hit         (evt_hit),
        .evt_dirty_before(evt_dirty_before),
        .evt_hazard      (evt_hazard),
        .inc             (inc)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        cec_sat_counter #(
            .COUNT_W(COUNT_W),
            .INC_W  (SEG_W)
        ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_req),
            .inc  (inc[g]),
            .count(cnt_q[g])
        );
    end

    cec_read_port #(
        .COUNT_W(COUNT_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .counts  (cnt_q),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cec_checker.sv
// Property checker for the counter bank, bound to every instance of the top.
module cec_checker
    import cec_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            txn_valid,
    input logic                            evt_valid,
    input logic                            evt_write,
    input logic                            evt_hit,
    input logic                            evt_dirty_before,
    input logic                            evt_hazard,
    input logic                            rd_en,
    input logic [2:0]                      rd_idx,
    input logic                            rd_valid,
    input logic [COUNT_W-1:0]              rd_data,
    input logic                            clr_req,
    input logic [NUM_CNT-1:0][COUNT_W-1:0] cnt_q
);
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt_q == '0));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_mono
        a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_req |=> (cnt_q[g] >= $past(cnt_q[g])));
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r9_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == IDX_CTRL) |=> (rd_data == '0));

    a_r11_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_hit && !txn_valid && !clr_req) |=> $stable(cnt_q));

    a_r4_dirty_no_first: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_write && evt_hit && evt_dirty_before && !clr_req)
        |=> $stable(cnt_q[IDX_WR_FIRST]));

    a_r5_lock_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_write && evt_hit && evt_hazard && !clr_req
         && cnt_q[IDX_RD_HIT] != '1)
        |=> (cnt_q[IDX_RD_HIT] != $past(cnt_q[IDX_RD_HIT])));

endmodule

bind cache_event_counters cec_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .txn_valid       (txn_valid),
    .evt_valid       (evt_valid),
    .evt_write       (evt_write),
    .evt_hit         (evt_hit),
    .evt_dirty_before(evt_dirty_before),
    .evt_hazard      (evt_hazard),
    .rd_en           (rd_en),
    .rd_idx          (rd_idx),
    .rd_valid        (rd_valid),
    .rd_data         (rd_data),
    .clr_req         (clr_req),
    .cnt_q           (cnt_q)
);

// File: tb/test_cache_event_counters.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model compared on every clock.
module test_cache_event_counters;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 12;
    localparam int COUNT_W = 8;
    localparam longint CMAX = (64'd1 << COUNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 0, txn_write = 0, txn_single = 0;
    logic [ADDR_W-1:0] txn_addr = '0;
    logic [LEN_W-1:0]  txn_len = '0;
    logic evt_valid = 0, evt_write = 0, evt_hit = 0, evt_dirty_before = 0, evt_hazard = 0;
    logic rd_en = 0;
    logic [2:0] rd_idx = '0;
    logic wr_en = 0;
    logic [2:0] wr_idx = '0;
    logic rd_valid;
    logic [COUNT_W-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    longint model [7];
    bit     exp_v;
    longint exp_d;
    int     exp_idx;

    always #5 clk = ~clk;

    cache_event_counters #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(64),
                           .COUNT_W(COUNT_W)) i_cache_event_counters (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_write(txn_write), .txn_single(txn_single),
        .txn_addr(txn_addr), .txn_len(txn_len),
        .evt_valid(evt_valid), .evt_write(evt_write), .evt_hit(evt_hit),
        .evt_dirty_before(evt_dirty_before), .evt_hazard(evt_hazard),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx));

    function automatic string req_of(int idx);
        case (idx)
            0, 1:    return "R1";
            2:       return "R6";
            3:       return "R3";
            4:       return "R4";
            5, 6:    return "R5";
            default: return "R9";
        endcase
    endfunction

    function automatic longint sat_add(longint a, longint b);
        return (a + b > CMAX) ? CMAX : a + b;
    endfunction

    // Reference model: segment count per R1, R2, R12.
    function automatic longint segs(longint addr, longint len, bit single);
        if (len == 0) return 0;
        if (single) return 1;
        return ((addr + len - 1) / 64) - (addr / 64) + 1;
    endfunction

    // Reference model update at each edge (R10 reset, R8 clear wins).
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (model[i]) model[i] = 0;
            exp_v = 0;
        end else begin
            exp_v   = rd_en;
            exp_idx = int'(rd_idx);
            exp_d   = (rd_idx < 3'd7) ? model[rd_idx] : 0;
            if (wr_en && wr_idx == 3'd7) begin
                foreach (model[i]) model[i] = 0;
            end else begin
                if (txn_valid) begin
                    longint s;
                    s = segs(longint'(txn_addr), longint'(txn_len), txn_single);
                    if (txn_write) model[1] = sat_add(model[1], s);
                    else           model[0] = sat_add(model[0], s);
                end
                if (evt_valid && evt_hit) begin
                    if (evt_write) begin
                        model[3] = sat_add(model[3], 1);
                        if (!evt_dirty_before) model[4] = sat_add(model[4], 1);
                        if (evt_hazard) model[6] = sat_add(model[6], 1);
                    end else begin
                        model[2] = sat_add(model[2], 1);
                        if (evt_hazard) model[5] = sat_add(model[5], 1);
                    end
                end
            end
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_valid !== exp_v) begin
                fails++;
                $display("FAIL R9 rd_valid actual=%0b expected=%0b", rd_valid, exp_v);
            end
            if (exp_v) begin
                checks++;
                if (longint'(rd_data) !== exp_d) begin
                    fails++;
                    $display("FAIL %s idx %0d rd_data actual=%0d expected=%0d",
                             req_of(exp_idx), exp_idx, rd_data, exp_d);
                end
            end
        end
    end

    task automatic idle();
        txn_valid = 0; txn_single = 0; evt_valid = 0; evt_hazard = 0;
        rd_en = 0; wr_en = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic txn(bit wr, bit single, logic [ADDR_W-1:0] a, int len);
        txn_valid = 1; txn_write = wr; txn_single = single;
        txn_addr = a; txn_len = LEN_W'(len);
        step();
    endtask

    task automatic evt(bit wr, bit hit, bit dirty, bit haz);
        evt_valid = 1; evt_write = wr; evt_hit = hit;
        evt_dirty_before = dirty; evt_hazard = haz;
        step();
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) begin
            rd_en = 1; rd_idx = 3'(i);
            step();
        end
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state reads zero
        read_all();

        // R1: segment spans, including boundary and top-of-memory cases
        txn(0, 0, 32'h0000_0000, 64);   // exactly one line
        txn(0, 0, 32'h0000_003F, 2);    // straddles one boundary
        txn(1, 0, 32'h0000_0040, 128);  // two aligned lines
        txn(1, 0, 32'hFFFF_FFF0, 64);   // end beyond top of memory
        txn(0, 0, 32'h1234_5601, 4095); // maximum length
        // R2: single-line port forces one segment
        txn(1, 1, 32'h0000_0030, 200);
        // R12: zero length adds nothing
        txn(0, 0, 32'h0000_0010, 0);
        read_all();

        // R6, R3, R4, R5: hit mix
        evt(0, 1, 0, 0);
        evt(0, 1, 1, 1);
        evt(1, 1, 0, 0);
        evt(1, 1, 1, 0);
        evt(1, 1, 1, 1);
        evt(1, 1, 0, 1);
        // R11: misses change nothing
        evt(0, 0, 0, 1);
        evt(1, 0, 0, 1);
        // event and read in the same cycle: read sees the value before it
        evt_valid = 1; evt_write = 1; evt_hit = 1; evt_dirty_before = 0;
        rd_en = 1; rd_idx = 3'd3;
        step();
        read_all();

        // R7: saturation by multi-segment increments and by single hits
        for (int k = 0; k < 5; k++) txn(0, 0, 32'h0000_0000, 4095);
        for (int k = 0; k < 300; k++) evt(1, 1, 0, 1);
        read_all();

        // R8: clear with concurrent events, clear wins
        wr_en = 1; wr_idx = 3'd7;
        txn_valid = 1; txn_write = 1; txn_single = 0; txn_addr = '0; txn_len = 12'd100;
        evt_valid = 1; evt_write = 0; evt_hit = 1; evt_hazard = 1;
        step();
        read_all();
        // write to a non-control index does not clear (R8)
        evt(0, 1, 0, 0);
        wr_en = 1; wr_idx = 3'd2;
        step();
        read_all();

        repeat (2) step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule